// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave with Write Lock

This block is a byte-addressed memory that answers as a slave on a two-wire serial bus. The clock and data lines are sampled through synchronizers running on the block's own system clock. START and STOP conditions are found on the sampled lines. The slave takes a device select byte and then a two-byte memory address. It then accepts write data or returns read data. It answers on the data line only by asserting a pull-low enable that drives an open-drain pad.

Written bytes collect in a page buffer. They reach the array only when the bus master ends the transfer with STOP. A write-lock input blocks a whole write transaction when it is high at any point between START and the last bit of the second address byte. In a blocked transaction every data byte is answered with a no-acknowledge and the array is left untouched. The default configuration holds 2 KB (`ADDR_W` = 11). Setting `ADDR_W` = 13 gives 8 KB. Address bits at and above `ADDR_W` are ignored.

The controller is one state machine with these states: IDLE, DEV (shifting in the select byte), DEV_ACK, AHI (high address byte), AHI_ACK, ALO (low address byte), ALO_ACK, WDAT (write data byte), WDAT_ACK, RDAT (shifting out a read byte), RDAT_ACK (sampling the master's answer) and IGNORE. START moves any state to DEV. STOP moves any state to IDLE. After eight bits, DEV goes to DEV_ACK when the select byte matches and to IGNORE when it does not. DEV_ACK goes to RDAT when the direction bit is 1 and to AHI when it is 0. AHI goes to AHI_ACK, then to ALO, then to ALO_ACK, then to WDAT. WDAT and WDAT_ACK alternate for as long as data bytes arrive. RDAT goes to RDAT_ACK. RDAT_ACK returns to RDAT when the master acknowledges and goes to IGNORE when it does not.

Top module: `twi_mem_slave`

## Requirements
- R1: A select byte whose upper seven bits equal 7'b1010000 gets an acknowledge: `sda_pull` = 1 for the whole ninth clock. Any other value gets no acknowledge, and the slave stays silent on every later byte until the next START.
- R2: Bit 0 of the select byte sets the direction: 0 means write (an address follows) and 1 means read (data is returned at once).
- R3: After a write select, the slave takes two address bytes, most significant first, and acknowledges each one. Address bits 15 down to `ADDR_W` are ignored.
- R4: In a byte write with the lock low, the data byte is acknowledged. After STOP, the location reads back the written value.
- R5: In a page write, every data byte is acknowledged and stored at the next address. The address advances only in its low 5 bits, so the 33rd byte lands back at the start of the 32-byte page.
- R6: If `wc_in` is high at any time from START through the second address byte, the select and address bytes are still acknowledged. Every data byte then gets a no-acknowledge and the array is not modified. A high lock that arrives only during the data bytes has no effect.
- R7: Write data reaches the array only at STOP. A START that arrives before the STOP discards the buffered bytes.
- R8: A read returns the byte at the internal address counter. The counter advances after every byte and wraps from the top of the array to 0. A read with no address phase continues from where the counter was left.
- R9: A write select followed by two address bytes and then a repeated START with a read select gives a read from that address.
- R10: After the master answers a read byte with a no-acknowledge, the slave drives the line no further until the next START.
- R11: A START at any point, including mid-byte, restarts select-byte reception. Out of reset the line is released.
- R12: `sda_pull` changes only while the synchronized clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad (wired value) |
| wc_in | input | 1 | Write lock, active high |
| sda_pull | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
The device select decode is swept over all 128 seven-bit select values. This shows that only one value is acknowledged, and that a rejected select stays silent on a following byte. Write patterns are a single byte with garbage in the upper address bits, a full aligned page, and a short burst that crosses the page end. Together they separate the correct wrap-within-page behaviour from a linear address count and from masking of the upper bits. The lock is raised in three places: during the select byte, during the low address byte only, and during the data bytes only. The first two must block the write and the third must not, which shows where the window ends. Reads are done as random reads, as current-address continuations and across the top of the array, so the counter increment and wrap are checked apart from the write path.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK,
        ST_IGNORE
    } state_t;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/twi_cond_detect.sv
module twi_cond_detect #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic wc_in,
    output logic scl_s,
    output logic sda_s,
    output logic wc_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_N-1:0] scl_ff, sda_ff, wc_ff;
    logic              scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            wc_ff  <= '0;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_N-2:0], scl_in};
            sda_ff <= {sda_ff[SYNC_N-2:0], sda_in};
            wc_ff  <= {wc_ff[SYNC_N-2:0], wc_in};
            scl_d  <= scl_ff[SYNC_N-1];
            sda_d  <= sda_ff[SYNC_N-1];
        end
    end

    assign scl_s     = scl_ff[SYNC_N-1];
    assign sda_s     = sda_ff[SYNC_N-1];
    assign wc_s      = wc_ff[SYNC_N-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    // Data edges while the clock stays high mark bus conditions
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     wr_en,
    input  logic [PAGE_W-1:0]        wr_off,
    input  logic [7:0]               wr_data,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] commit_page,
    output logic                     busy,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_waddr,
    output logic [7:0]               mem_wdata
);

    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0]               data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]    valid_q;
    logic [PAGE_W-1:0]        idx_q;
    logic [ADDR_W-PAGE_W-1:0] page_q;
    logic                     busy_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_off] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            idx_q   <= '0;
            page_q  <= '0;
            busy_q  <= 1'b0;
        end else if (busy_q) begin
            // Drain one slot per cycle, clearing it behind the scan
            valid_q[idx_q] <= 1'b0;
            idx_q          <= idx_q + 1'b1;
            if (idx_q == '1) begin
                busy_q <= 1'b0;
            end
        end else if (commit) begin
            busy_q <= |valid_q;
            page_q <= commit_page;
            idx_q  <= '0;
        end else if (clear) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_off] <= 1'b1;
        end
    end

    assign busy      = busy_q;
    assign mem_we    = busy_q & valid_q[idx_q];
    assign mem_waddr = {page_q, idx_q};
    assign mem_wdata = data_q[idx_q];

endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int         ADDR_W = 11,
    parameter int         PAGE_W = 5,
    parameter int         SYNC_N = 2,
    parameter logic [6:0] DEV_ID = 7'b1010000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic wc_in,
    output logic sda_pull
);

    localparam int HI_W = ADDR_W - BYTE_BITS;

    logic scl_s, sda_s, wc_s, scl_rise, scl_fall, start_det, stop_det;

    state_t            state_q;
    logic [3:0]        bit_cnt_q;
    logic [7:0]        shreg_q;
    logic [7:0]        tx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              ack_q, lock_q, rd_q, mack_q;

    logic              in_window, byte_done;
    logic              buf_wr, buf_commit, commit_busy;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata, mem_rdata;

    twi_cond_detect #(.SYNC_N(SYNC_N)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .wc_in     (wc_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .wc_s      (wc_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (start_det),
        .wr_en       (buf_wr),
        .wr_off      (addr_q[PAGE_W-1:0]),
        .wr_data     (shreg_q),
        .commit      (buf_commit),
        .commit_page (addr_q[ADDR_W-1:PAGE_W]),
        .busy        (commit_busy),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .mem_wdata   (mem_wdata)
    );

    twi_mem_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (addr_q),
        .rdata (mem_rdata)
    );

    // Lock qualification window: START up to the end of the low address byte
    assign in_window = (state_q == ST_DEV) || (state_q == ST_DEV_ACK) ||
                       (state_q == ST_AHI) || (state_q == ST_AHI_ACK) ||
                       (state_q == ST_ALO);
    assign byte_done = scl_fall && (bit_cnt_q == 4'd8);
    assign buf_wr    = (state_q == ST_WDAT) && byte_done && !lock_q &&
                       !start_det && !stop_det;
    assign buf_commit = stop_det &&
                        ((state_q == ST_WDAT) || (state_q == ST_WDAT_ACK));

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            tx_q      <= '1;
            addr_q    <= '0;
            ack_q     <= 1'b0;
            lock_q    <= 1'b0;
            rd_q      <= 1'b0;
            mack_q    <= 1'b0;
        end else if (start_det) begin
            state_q   <= ST_DEV;
            bit_cnt_q <= '0;
            ack_q     <= 1'b0;
            lock_q    <= wc_s;
        end else if (stop_det) begin
            state_q <= ST_IDLE;
            ack_q   <= 1'b0;
        end else begin
            if (in_window && wc_s) begin
                lock_q <= 1'b1;
            end
            unique case (state_q)
                ST_IDLE, ST_IGNORE: begin
                end
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise) begin
                        shreg_q   <= {shreg_q[6:0], sda_s};
                        bit_cnt_q <= bit_cnt_q + 4'd1;
                    end else if (byte_done) begin
                        bit_cnt_q <= '0;
                        if (state_q == ST_DEV) begin
                            if (shreg_q[7:1] == DEV_ID) begin
                                state_q <= ST_DEV_ACK;
                                ack_q   <= 1'b1;
                                rd_q    <= shreg_q[0];
                            end else begin
                                state_q <= ST_IGNORE;
                            end
                        end else if (state_q == ST_AHI) begin
                            addr_q[ADDR_W-1:BYTE_BITS] <= shreg_q[HI_W-1:0];
                            state_q <= ST_AHI_ACK;
                            ack_q   <= 1'b1;
                        end else if (state_q == ST_ALO) begin
                            addr_q[BYTE_BITS-1:0] <= shreg_q;
                            state_q <= ST_ALO_ACK;
                            ack_q   <= 1'b1;
                        end else begin
                            state_q <= ST_WDAT_ACK;
                            ack_q   <= !lock_q;
                            if (!lock_q) begin
                                addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
                            end
                        end
                    end
                end
                ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: begin
                    if (scl_fall) begin
                        ack_q     <= 1'b0;
                        bit_cnt_q <= '0;
                        if (state_q == ST_DEV_ACK) begin
                            if (rd_q) begin
                                state_q <= ST_RDAT;
                                tx_q    <= mem_rdata;
                                addr_q  <= addr_q + 1'b1;
                            end else begin
                                state_q <= ST_AHI;
                            end
                        end else if (state_q == ST_AHI_ACK) begin
                            state_q <= ST_ALO;
                        end else begin
                            state_q <= ST_WDAT;
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        bit_cnt_q <= bit_cnt_q + 4'd1;
                    end else if (byte_done) begin
                        bit_cnt_q <= '0;
                        tx_q      <= '1;
                        state_q   <= ST_RDAT_ACK;
                    end else if (scl_fall) begin
                        tx_q <= {tx_q[6:0], 1'b1};
                    end
                end
                ST_RDAT_ACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_s;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            state_q <= ST_RDAT;
                            tx_q    <= mem_rdata;
                            addr_q  <= addr_q + 1'b1;
                        end else begin
                            state_q <= ST_IGNORE;
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        sda_pull = ack_q || ((state_q == ST_RDAT) && !tx_q[7]);
    end

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
    import twi_mem_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input state_t     state_q,
    input logic [3:0] bit_cnt_q,
    input logic       lock_q,
    input logic       commit_busy,
    input logic       sda_pull
);

    a_r12_pull_moves_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_s);

    a_r6_locked_data_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDAT_ACK && lock_q) |-> !sda_pull);

    a_r11_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_DEV && bit_cnt_q == 4'd0));

    a_r1_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !sda_pull);

    a_r7_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(commit_busy) |-> $past(stop_det));

    a_r11_bit_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_q <= 4'd8);

endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .state_q     (state_q),
    .bit_cnt_q   (bit_cnt_q),
    .lock_q      (lock_q),
    .commit_busy (commit_busy),
    .sda_pull    (sda_pull)
);

// File: tb/tb_twi_mem_slave.sv
module tb_twi_mem_slave;

    localparam int Q      = 6;
    localparam int AW     = 11;
    localparam int DEPTH  = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wc = 1'b0;
    logic sda_pull;
    logic sda_bus;

    int checks = 0;
    int bad = 0;
    int r12_viol = 0;
    bit finished = 1'b0;
    logic pull_prev = 1'b0;
    logic [7:0] mdl [DEPTH];

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    twi_mem_slave dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_m),
        .sda_in   (sda_bus),
        .wc_in    (wc),
        .sda_pull (sda_pull)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; half(); scl_m = 1'b1; half();
        sda_m = 1'b0; half(); scl_m = 1'b0; half();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; half(); scl_m = 1'b1; half(); sda_m = 1'b1; half();
        repeat (48) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        sda_m = b; half(); scl_m = 1'b1; half();
        seen = sda_bus; half(); scl_m = 1'b0; half();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, s);
            d = {d[6:0], s};
        end
        clock_bit(nack, s);
    endtask

    // wc_mode: 0 none, 1 during select byte, 2 during low address, 3 during data
    task automatic do_write(input logic [15:0] a, input int n, input logic [7:0] v0,
                            input logic [7:0] step, input int wc_mode, input bit allow);
        bit ack;
        logic [AW-1:0] loc;
        logic [4:0] off;
        if (wc_mode == 1) wc = 1'b1;
        bus_start();
        send_byte(8'hA0, ack);
        chk(ack, "R1 write select ack", ack, 1);
        if (wc_mode == 1) wc = 1'b0;
        send_byte(a[15:8], ack);
        chk(ack, "R3 high address ack", ack, 1);
        if (wc_mode == 2) wc = 1'b1;
        send_byte(a[7:0], ack);
        chk(ack, "R3 low address ack", ack, 1);
        if (wc_mode == 2) wc = 1'b0;
        if (wc_mode == 3) wc = 1'b1;
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = v0 + 8'(i) * step;
            send_byte(v, ack);
            if (allow) chk(ack == 1'b1, "R5 data byte ack (R4)", ack, 1);
            else       chk(ack == 1'b0, "R6 data byte nack when locked", ack, 0);
            if (allow) begin
                off = a[4:0] + 5'(i);
                loc = {a[AW-1:5], off};
                mdl[loc] = v;
            end
        end
        bus_stop();
        wc = 1'b0;
    endtask

    task automatic read_bytes(input logic [AW-1:0] a, input int n, input string req);
        logic [7:0] d;
        logic [AW-1:0] loc;
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, d);
            loc = a + AW'(i);
            chk(d == mdl[loc], req, d, mdl[loc]);
        end
    endtask

    task automatic rand_read(input logic [15:0] a, input int n, input bit tail_check);
        bit ack;
        logic s;
        int seen_low;
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(a[15:8], ack);
        send_byte(a[7:0], ack);
        bus_start();
        send_byte(8'hA1, ack);
        chk(ack, "R2 read select ack", ack, 1);
        read_bytes(a[AW-1:0], n, "R9 random read data (R8)");
        if (tail_check) begin
            seen_low = 0;
            for (int i = 0; i < 9; i++) begin
                clock_bit(1'b1, s);
                if (!s) seen_low++;
            end
            chk(seen_low == 0, "R10 line released after master nack", seen_low, 0);
        end
        bus_stop();
    endtask

    task automatic cur_read(input logic [AW-1:0] a, input int n);
        bit ack;
        bus_start();
        send_byte(8'hA1, ack);
        chk(ack, "R2 current read select ack", ack, 1);
        read_bytes(a, n, "R8 current address read data");
        bus_stop();
    endtask

    always @(negedge clk) begin
        if (rst_n && (sda_pull !== pull_prev) && scl_m) r12_viol++;
        pull_prev = sda_pull;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic s;
        repeat (5) @(negedge clk);
        chk(sda_pull == 1'b0, "R11 reset releases line", sda_pull, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: sweep all seven-bit select values
        for (int id = 0; id < 128; id++) begin
            bus_start();
            send_byte({7'(id), 1'b0}, ack);
            chk(ack == (id == 'h50), "R1 select decode", ack, id == 'h50);
            if (id != 'h50) begin
                send_byte(8'hA0, ack);
                chk(ack == 1'b0, "R1 silent after mismatch", ack, 0);
            end
            bus_stop();
        end

        // R3/R4: byte write with garbage in upper address bits
        do_write(16'hF923, 1, 8'h6E, 8'h00, 0, 1);
        rand_read(16'h0123, 1, 1'b1);

        // R5: full aligned page, then burst wrapping past the page end
        do_write(16'h0040, 32, 8'h03, 8'h07, 0, 1);
        do_write(16'h005C, 8, 8'hA0, 8'h01, 0, 1);
        rand_read(16'h0040, 16, 1'b0);
        cur_read(11'h050, 16);

        // R6: lock windows
        do_write(16'h0040, 4, 8'h55, 8'h11, 1, 0);
        do_write(16'h0044, 4, 8'h99, 8'h11, 2, 0);
        do_write(16'h0048, 4, 8'h66, 8'h01, 3, 1);
        rand_read(16'h0040, 16, 1'b0);

        // R7: repeated START before STOP drops buffered data
        do_write(16'h0100, 1, 8'h3C, 8'h00, 0, 1);
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h01, ack);
        send_byte(8'h00, ack);
        send_byte(8'hC3, ack);
        bus_start();
        bus_stop();
        rand_read(16'h0100, 1, 1'b0);

        // R8: counter wraps at the top of the array
        do_write(16'h07FF, 1, 8'h9A, 8'h00, 0, 1);
        do_write(16'h0000, 1, 8'h5B, 8'h00, 0, 1);
        rand_read(16'h07FF, 2, 1'b0);

        // R11: START in the middle of a byte restarts select reception
        bus_start();
        for (int i = 0; i < 4; i++) clock_bit(1'b1, s);
        bus_start();
        send_byte(8'hA0, ack);
        chk(ack, "R11 select after mid-byte START", ack, 1);
        bus_stop();

        chk(r12_viol == 0, "R12 pull changes only with clock low", r12_viol, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule